// File: doc/BRIEF.md
# Chainable RAM Tile with Masked Self-Select

One synchronous RAM tile that is built to be strung together with identical tiles into a deeper memory. Every tile in a chain sees the same wide address, write enable, write data and read enable. A tile claims an access when the upper address field, bits 25:15, matches a per-instance self address in every bit that a per-instance mask leaves visible. Mask bits set to 1 are ignored, so the default all-ones mask makes a lone tile that claims every access. Chains grow by clearing mask bits from the low end of the field: `11'h7fe` spans two tiles, `11'h7fc` up to four, and so on down to `11'h000`.

Read data moves toward the exit of the chain through a cascade path. Each tile has a role: unchained, first, middle or last. A first or unchained tile ignores its cascade inputs. A middle or last tile passes the incoming data and valid flag on, unless it supplied the read itself, in which case its own registered word takes their place. The last tile's cascade outputs are the chain's read result and read-valid flag. Masked selection works the same way for an unchained tile, so scattered tiles can be combined by outside logic. Each tile in one chain must have a distinct mask and self-address pair, so that exactly one tile answers each read.

Top module: `casc_ram_tile`

## Requirements
- R1: A tile is selected when `((addr[25:15] ^ SELF_ADDR) & ~SEL_MASK) == 0`. Address bits in the field whose mask bit is 1 do not affect selection.
- R2: With the default mask `11'h7ff`, the tile is selected for every address.
- R3: A write (`we`=1) updates word `addr[LOCAL_AW-1:0]` only in the selected tile. Every tile that is not selected keeps all of its words unchanged.
- R4: A read (`re`=1) on a selected tile raises `cout_vld` in the cycle after the clock edge that samples `re`. In that cycle `cout_data` holds the addressed word.
- R5: If the same edge has a write and a read to the same word, the read returns the word's contents from before that write.
- R6: `CHAIN_POS` 0 (unchained) and 1 (first) ignore `cin_data` and `cin_vld`. If the tile did not supply a read on the previous edge, `cout_vld` is 0 and `cout_data` is 0.
- R7: `CHAIN_POS` 2 (middle) and 3 (last) drive `cout_vld`/`cout_data` from `cin_vld`/`cin_data` when the tile did not supply a read on the previous edge. Otherwise they drive 1 and their own read word.
- R8: In a four-tile chain with mask `11'h7fc` and self addresses 0 to 3, `addr[16:15]` picks the tile. Bits 25:17 are ignored, and the last tile's cascade outputs give the right word for every tile.
- R9: An unchained tile with a partial mask (`11'h7fe`, self address 1) answers only addresses whose bit 15 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read-valid state |
| addr | input | ADDR_W | Word address; bits 25:15 are the select field, low LOCAL_AW bits index the tile |
| we | input | 1 | Write enable |
| wdata | input | DATA_W | Write data |
| re | input | 1 | Read enable |
| cin_data | input | DATA_W | Read data arriving from the previous tile |
| cin_vld | input | 1 | Valid flag arriving with cin_data |
| cout_data | output | DATA_W | Read data passed toward the chain exit |
| cout_vld | output | 1 | Valid flag passed with cout_data |

## Verification
The bench ties the first tile's cascade input to a valid-looking constant. A first tile that failed to ignore that input would produce unrequested read-valid pulses at the exit. Writes aimed at one tile are followed by reads of the same word index in every other tile, which catches a select that drops the mask or compares the wrong bits. Reads set high address bits that the mask hides, and same-cycle read/write collisions must return the old word. The partial-mask and default-mask standalone tiles catch a select that inverts the meaning of mask bits.

// File: rtl/casc_ram_tile.sv
module casc_ram_tile #(
  parameter int DATA_W = 16,
  parameter int LOCAL_AW = 6,
  parameter int ADDR_W = 26,
  parameter int SEL_LSB = 15,
  parameter int SEL_W = 11,
  parameter int CHAIN_POS = 0,
  parameter logic [10:0] SEL_MASK = 11'h7ff,
  parameter logic [10:0] SELF_ADDR = 11'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [DATA_W-1:0] cin_data,
  input  logic              cin_vld,
  output logic [DATA_W-1:0] cout_data,
  output logic              cout_vld
);
  localparam int DEPTH = 1 << LOCAL_AW;
  localparam bit FWD = (CHAIN_POS == 2) || (CHAIN_POS == 3);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              own_vld;

  wire [SEL_W-1:0]    sel_field = addr[SEL_LSB +: SEL_W];
  wire                hit = ((sel_field ^ SELF_ADDR[SEL_W-1:0]) & ~SEL_MASK[SEL_W-1:0]) == '0;
  wire [LOCAL_AW-1:0] idx = addr[LOCAL_AW-1:0];
  wire                unused_addr = ^addr;

  always_ff @(posedge clk) begin
    if (we && hit) mem[idx] <= wdata;
    if (re && hit) rd_q <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_vld <= 1'b0;
    else        own_vld <= re && hit;
  end

  generate
    if (FWD) begin : g_fwd
      assign cout_vld  = own_vld | cin_vld;
      assign cout_data = own_vld ? rd_q : cin_data;
    end else begin : g_head
      wire unused_cin = ^{cin_data, cin_vld};
      assign cout_vld  = own_vld;
      assign cout_data = own_vld ? rd_q : '0;
    end
  endgenerate
endmodule

// File: rtl/casc_ram_tile_chk.sv
module casc_ram_tile_chk #(
  parameter int DATA_W = 16,
  parameter int LOCAL_AW = 6,
  parameter int ADDR_W = 26,
  parameter int SEL_LSB = 15,
  parameter int SEL_W = 11,
  parameter int CHAIN_POS = 0,
  parameter logic [10:0] SEL_MASK = 11'h7ff,
  parameter logic [10:0] SELF_ADDR = 11'h000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [DATA_W-1:0] wdata,
  input logic              re,
  input logic [DATA_W-1:0] cin_data,
  input logic              cin_vld,
  input logic [DATA_W-1:0] cout_data,
  input logic              cout_vld
);
  localparam bit PASS = (CHAIN_POS == 2) || (CHAIN_POS == 3);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  logic mine;
  always_comb begin
    mine = 1'b1;
    for (int i = 0; i < SEL_W; i++)
      if (!SEL_MASK[i] && (addr[SEL_LSB+i] != SELF_ADDR[i])) mine = 1'b0;
  end
  wire re_mine = re && mine;
  wire we_mine = we && mine;
  wire [LOCAL_AW-1:0] loc = addr[LOCAL_AW-1:0];

  // R4
  vld_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && cout_vld) |-> ($past(re_mine) || (PASS && cin_vld)));

  // R6
  head_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!PASS && cyc != 2'd0 && !$past(re_mine)) |-> (!cout_vld && cout_data == '0));

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PASS && cyc != 2'd0 && !$past(re_mine)) |-> (cout_vld == cin_vld && cout_data == cin_data));

  // R5
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && $past(we_mine, 2) && $past(re_mine) && $past(loc) == $past(loc, 2))
      |-> (cout_vld && cout_data == $past(wdata, 2)));
endmodule

bind casc_ram_tile casc_ram_tile_chk #(
  .DATA_W(DATA_W), .LOCAL_AW(LOCAL_AW), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB),
  .SEL_W(SEL_W), .CHAIN_POS(CHAIN_POS), .SEL_MASK(SEL_MASK), .SELF_ADDR(SELF_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .re(re),
  .cin_data(cin_data), .cin_vld(cin_vld), .cout_data(cout_data), .cout_vld(cout_vld)
);

// File: tb/tb_casc_ram_tile.sv
module tb_casc_ram_tile;
  localparam int DW = 16;
  localparam int LAW = 6;
  localparam int AW = 26;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic we = 0, re = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] c_data [5];
  logic          c_vld  [5];
  logic [DW-1:0] b_data, c2_data;
  logic          b_vld, c2_vld;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign c_data[0] = 16'hdead;
  assign c_vld[0]  = 1'b1;

  for (genvar g = 0; g < 4; g++) begin : g_tile
    casc_ram_tile #(.DATA_W(DW), .LOCAL_AW(LAW), .ADDR_W(AW),
      .CHAIN_POS(g == 0 ? 1 : (g == 3 ? 3 : 2)),
      .SEL_MASK(11'h7fc), .SELF_ADDR(11'(g))) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .re(re),
      .cin_data(c_data[g]), .cin_vld(c_vld[g]),
      .cout_data(c_data[g+1]), .cout_vld(c_vld[g+1]));
  end

  casc_ram_tile #(.DATA_W(DW), .LOCAL_AW(LAW), .ADDR_W(AW), .CHAIN_POS(0),
    .SEL_MASK(11'h7fe), .SELF_ADDR(11'h001)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .re(re),
    .cin_data(16'hbeef), .cin_vld(1'b1), .cout_data(b_data), .cout_vld(b_vld));

  casc_ram_tile #(.DATA_W(DW), .LOCAL_AW(LAW), .ADDR_W(AW)) dut_c (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .re(re),
    .cin_data(16'hbeef), .cin_vld(1'b1), .cout_data(c2_data), .cout_vld(c2_vld));

  // model: 0..3 chain tiles, 4 = partial-mask tile, 5 = default tile
  logic [DW-1:0] model [6][64];
  int            due_q [$];
  logic [DW-1:0] dat_q [$];
  string         req_q [$];

  function automatic bit picks(int t, logic [AW-1:0] a);
    if (t < 4) return a[16:15] == 2'(t);
    if (t == 4) return a[15];
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic [AW-1:0] a, bit w, logic [DW-1:0] d, bit r, string req);
    logic [DW-1:0] exp_b, exp_c;
    int idx = int'(a[LAW-1:0]);
    exp_b = model[4][idx];
    exp_c = model[5][idx];
    if (r) begin
      due_q.push_back(cyc + 1);
      dat_q.push_back(model[a[16:15]][idx]);
      req_q.push_back(req);
    end
    if (w) for (int t = 0; t < 6; t++) if (picks(t, a)) model[t][idx] = d;
    addr = a; we = w; wdata = d; re = r;
    @(negedge clk);
    we = 0; re = 0;
    if (r) begin
      chk(b_vld == a[15], "R9 vld", {15'd0, b_vld}, {15'd0, a[15]});
      if (a[15]) chk(b_data == exp_b, "R9 data", b_data, exp_b);
      else       chk(b_data == '0, "R6 idle data", b_data, '0);
      chk(c2_vld && c2_data == exp_c, "R2", c2_data, exp_c);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      chk(c_vld[4] == 1'b1, {req_q[0], " vld"}, {15'd0, c_vld[4]}, 16'd1);
      chk(c_data[4] == dat_q[0], req_q[0], c_data[4], dat_q[0]);
      void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(req_q.pop_front());
    end else if (c_vld[4]) begin
      chk(1'b0, "R6 unrequested exit valid", c_data[4], '0);
    end
  end

  initial begin
    #(20ns * 150000);
    chk(1'b0, "watchdog", '0, '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(c_vld[4] == 0 && b_vld == 0 && c2_vld == 0, "R4 reset", {15'd0, c_vld[4]}, '0);
    rst_n = 1;
    @(negedge clk);
    // fill every tile word: tile t at addr[16:15]
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 64; i++)
        access(AW'((t << 15) | i), 1, DW'((t << 12) ^ (i * 37) ^ 16'h5a00), 0, "");
    // R8: every tile answers at the exit
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 64; i += 9)
        access(AW'((t << 15) | i), 0, '0, 1, "R8 chain read");
    // R3: write into tile 2 only, others keep word 5
    access(AW'((2 << 15) | 5), 1, 16'hc0de, 0, "");
    for (int t = 0; t < 4; t++) access(AW'((t << 15) | 5), 0, '0, 1, "R3 isolation");
    // R1: masked high bits ignored by chain select
    access(AW'((1 << 20) | (1 << 25) | (3 << 15) | 7), 0, '0, 1, "R1 masked bits");
    access(AW'((1 << 17) | (1 << 15) | 9), 1, 16'h1234, 0, "");
    access(AW'((1 << 15) | 9), 0, '0, 1, "R1 masked write");
    // R4: back-to-back reads
    access(AW'((0 << 15) | 1), 0, '0, 1, "R4 b2b");
    access(AW'((3 << 15) | 2), 0, '0, 1, "R4 b2b");
    access(AW'((1 << 15) | 3), 0, '0, 1, "R4 b2b");
    // R5: read and write same word same edge
    access(AW'((2 << 15) | 11), 1, 16'hfeed, 1, "R5 read-first");
    access(AW'((2 << 15) | 11), 0, '0, 1, "R5 after write");
    // R7: idle cycles, no exit valid (monitor watches)
    repeat (4) @(negedge clk);
    chk(c_vld[4] == 0, "R7 idle exit", {15'd0, c_vld[4]}, '0);
    repeat (2) @(negedge clk);
    chk(due_q.size() == 0, "R4 all reads seen", DW'(due_q.size()), '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule